// File: doc/BRIEF.md
# Burst-Framed Synchronous Bit Serializer

This block turns a stream of bytes into a gap-free serial bit stream on one self-timed output pin. It advances one bit for every pulse of a bit-rate enable. Its storage is a single holding register, filled by an upstream feeder, and a shift register that drives the pin MSB first. A frame counter raises a load marker once every `DATA_W` bit periods. The bit enable that ends the marker copies the holding register into the shift register and sends the feeder a one-clock request for the next byte. The feeder therefore has a whole byte time to answer, and the outgoing bytes follow each other with no idle bit.

A burst opens with a one-clock start strobe, which pulls the active-low `active_n` flag low. That flag can, for example, key a transmitter. When the feeder has delivered its final byte it raises `done`. A chain of five termination stages then walks down in order. The first stage clears on `done`. The others clear, in turn, on a rising, falling, rising and falling edge of the load marker. The flag rises only when the last bit of the final byte has left the pin. While the flag is high, the frame counter and the shift register are held cleared.

Top module: `bser_top`

## Requirements
- R1: While `active_n` is high (idle, or in or after reset), `serial_o`, `frame_load` and `req` stay 0 whatever `bit_en` does, and `done` has no effect.
- R2: A one-clock `start` while idle drives `active_n` low from the next clock.
- R3: During a burst, `frame_load` goes high on the first `bit_en` after start. It stays high for exactly one bit period and repeats every `DATA_W` (8) bit periods.
- R4: The `bit_en` that ends a `frame_load` period copies the holding register into the shift register. From then on, `serial_o` shows that byte MSB first, one bit per bit period, and successive bytes follow with no gap.
- R5: Each such transfer, made before `done` has been seen, produces exactly one `req` pulse, one clock long, in the clock after the transfer edge.
- R6: `wr_en` writes `wr_data` into the holding register in any clock. A byte written before `start` is the first byte sent in the burst.
- R7: `done` clears the first termination stage. The feeder raises it after writing the final byte, and before the next rising edge of `frame_load`.
- R8: After `done`, `active_n` returns high at the `bit_en` that ends the final byte's LSB, which is also where `frame_load` falls. `serial_o` is 0 from that clock on.
- R9: A `start` pulse while `active_n` is low is ignored; the burst content and its end time are unchanged.
- R10: No `req` pulse occurs after `done` has been seen in a burst, including at the transfer of the final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-clock pulse per bit period |
| start | input | 1 | One-clock strobe that opens a burst |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Byte written into the holding register |
| done | input | 1 | Feeder has delivered its final byte |
| req | output | 1 | One-clock request for the next byte |
| frame_load | output | 1 | Load marker, one bit period per frame |
| serial_o | output | 1 | Serial data pin, MSB first |
| active_n | output | 1 | Active-low burst flag |

## Verification
The bench captures every bit period of two bursts and compares the pin, the load marker and the flag with values computed from the byte table. A refill placed one period late would leave a gap bit or repeat a byte. A termination chain one stage short would drop `active_n` before the final 0xA5 bit, cutting off its LSB. A chain one stage long would hold the flag for a further byte. It also counts requests: a design that still requests when the final byte is transferred shows one request too many. A restart while the flag is low, and `done` or `bit_en` activity while idle, are also applied. A design that honoured the restart would shift the stream or the end time. A design that honoured the idle inputs would move `frame_load` or `active_n` while idle.

// File: rtl/bser_pkg.sv
package bser_pkg;

    localparam int TERM_STAGES = 5;

    typedef struct packed {
        logic level;  // load marker
        logic rise;   // marker rises at this edge
        logic fall;   // marker falls at this edge (transfer)
    } load_ev_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FEED  = 2'd1,
        PH_DRAIN = 2'd2
    } burst_phase_t;

    // Stage k (k >= 1) is stepped by a rising marker edge for odd k and
    // a falling edge for even k.
    function automatic logic stage_step(input int k, input load_ev_t ev);
        return (k % 2 == 1) ? ev.rise : ev.fall;
    endfunction

endpackage

// File: rtl/bser_bit_timer.sv
module bser_bit_timer
    import bser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     bit_en,
    output load_ev_t ev
);
    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [CW-1:0] cnt;
    logic          level;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= LAST;
            level <= 1'b0;
        end else if (bit_en) begin
            level <= (cnt == LAST);
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        ev.level = level;
        ev.rise  = run && bit_en && (cnt == LAST);
        ev.fall  = run && bit_en && level;
    end

endmodule

// File: rtl/bser_shifter.sv
module bser_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              bit_en,
    input  logic              xfer,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              serial
);
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)        hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)  shreg <= '0;
        else if (xfer)    shreg <= hold_q;
        else if (bit_en)  shreg <= {shreg[DATA_W-2:0], 1'b0};
    end

    assign serial = run & shreg[DATA_W-1];

endmodule

// File: rtl/bser_term_chain.sv
module bser_term_chain
    import bser_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         done,
    input  load_ev_t     ev,
    output logic         active_n,
    output burst_phase_t phase
);
    logic [TERM_STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst)                             stg[0] <= 1'b0;
        else if (start && !stg[TERM_STAGES-1]) stg[0] <= 1'b1;
        else if (done)                       stg[0] <= 1'b0;
    end

    for (genvar k = 1; k < TERM_STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[k] <= 1'b0;
            else if (start && !stg[TERM_STAGES-1])
                stg[k] <= 1'b1;
            else if (!stg[k-1] && stage_step(k, ev))
                stg[k] <= 1'b0;
        end
    end

    assign active_n = !stg[TERM_STAGES-1];

    always_comb begin
        if (!stg[TERM_STAGES-1]) phase = PH_IDLE;
        else if (stg[0])         phase = PH_FEED;
        else                     phase = PH_DRAIN;
    end

endmodule

// File: rtl/bser_top.sv
module bser_top
    import bser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              start,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done,
    output logic              req,
    output logic              frame_load,
    output logic              serial_o,
    output logic              active_n
);
    load_ev_t     ev;
    burst_phase_t phase;
    logic         run;

    assign run = !active_n;

    bser_term_chain i_term (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .done     (done),
        .ev       (ev),
        .active_n (active_n),
        .phase    (phase)
    );

    bser_bit_timer #(.DATA_W(DATA_W)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .bit_en (bit_en),
        .ev     (ev)
    );

    bser_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .bit_en  (bit_en),
        .xfer    (ev.fall),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .serial  (serial_o)
    );

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= ev.fall && (phase == PH_FEED);
    end

    assign frame_load = ev.level;

endmodule

// File: rtl/bser_checker.sv
module bser_checker (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic start,
    input logic req,
    input logic frame_load,
    input logic active_n
);
    // R1: idle means no marker and no request
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (active_n && $past(active_n)) |-> (!frame_load && !req));

    // R2: start while idle opens the burst
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (start && active_n) |=> !active_n);

    // R3: marker lasts a single bit period
    assert_marker_width_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_load && bit_en && !active_n) |=> !frame_load);

    // R5: request follows the marker's falling edge
    assert_req_after_xfer_R5: assert property (@(posedge clk) disable iff (rst)
        req |-> ($past(frame_load) && !frame_load));

    // R5: request is one clock long
    assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R8: the flag rises only where the marker falls
    assert_end_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(active_n) |-> $fell(frame_load));

endmodule

bind bser_top bser_checker i_bser_checker (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .start      (start),
    .req        (req),
    .frame_load (frame_load),
    .active_n   (active_n)
);

// File: tb/test_bser_top.sv
module test_bser_top;
    localparam int W      = 8;
    localparam int NB_TOT = 7;
    localparam logic [W-1:0] VEC [NB_TOT] =
        '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hA5};

    logic clk = 1'b0;
    logic rst, bit_en, start, wr_en, done;
    logic [W-1:0] wr_data;
    logic req, frame_load, serial_o, active_n;

    always #2 clk = ~clk;

    bser_top #(.DATA_W(W)) i_bser_top (
        .clk(clk), .rst(rst), .bit_en(bit_en), .start(start),
        .wr_en(wr_en), .wr_data(wr_data), .done(done),
        .req(req), .frame_load(frame_load), .serial_o(serial_o),
        .active_n(active_n)
    );

    int n_chk = 0, n_fail = 0;
    int div = 0, feed_idx = 0, burst_end = 0, done_left = 0, req_cnt = 0;
    int nsmp = 0;
    logic capturing = 1'b0, prev_actn = 1'b1;
    logic smp_pin [0:127];
    logic smp_act [0:127];
    logic smp_ld  [0:127];

    task automatic check(input logic ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // one system clock: sample the last edge's results, then drive inputs
    task automatic tick();
        @(negedge clk);
        if (capturing && bit_en && !prev_actn && nsmp < 128) begin
            smp_pin[nsmp] = serial_o;
            smp_act[nsmp] = active_n;
            smp_ld[nsmp]  = frame_load;
            nsmp++;
        end
        prev_actn = active_n;
        wr_en = 1'b0;
        if (req) begin
            req_cnt++;
            if (feed_idx < burst_end) begin
                wr_en   = 1'b1;
                wr_data = VEC[feed_idx];
                feed_idx++;
                if (feed_idx == burst_end) done_left = 2;
            end
        end
        done = (done_left > 0);
        if (done_left > 0) done_left--;
        bit_en = (div == 0);
        div = (div + 1) % 3;
    endtask

    task automatic run_burst(input int base, input int len, input logic restart);
        int total;
        total = 8 * len + 2;
        wr_en = 1'b1; wr_data = VEC[base];        // R6 preload before start
        tick();
        feed_idx = base + 1; burst_end = base + len;
        nsmp = 0; req_cnt = 0; capturing = 1'b1;
        start = 1'b1;
        tick();
        start = 1'b0;
        check(active_n == 1'b0, "R2", active_n, 0);
        for (int t = 0; t < 4000 && nsmp < total; t++) begin
            if (restart && nsmp == 10) begin
                start = 1'b1; tick(); start = 1'b0;   // R9 ignored restart
            end else begin
                tick();
            end
        end
        capturing = 1'b0;
        check(nsmp == total, "R8 sample count", nsmp, total);
        for (int k = 0; k < total; k++) begin
            logic e_pin, e_act, e_ld;
            e_act = (k > 8 * len);
            e_ld  = (k % 8 == 0) && (k <= 8 * len);
            if (k == 0 || k > 8 * len) e_pin = 1'b0;
            else e_pin = VEC[base + (k - 1) / 8][7 - ((k - 1) % 8)];
            check(smp_pin[k] == e_pin, "R4 serial bit", smp_pin[k], e_pin);
            check(smp_act[k] == e_act, "R8 active_n", smp_act[k], e_act);
            check(smp_ld[k] == e_ld, "R3 frame_load", smp_ld[k], e_ld);
        end
        check(req_cnt == len - 1, "R5 R10 request count", req_cnt, len - 1);
        req_cnt = 0;
        for (int t = 0; t < 40; t++) begin
            tick();
            check(active_n && !serial_o && !frame_load, "R1 R8 after burst",
                  {active_n, serial_o, frame_load}, 4);
        end
        check(req_cnt == 0, "R10 no late request", req_cnt, 0);
    endtask

    initial begin
        rst = 1'b1; bit_en = 1'b0; start = 1'b0; wr_en = 1'b0;
        wr_data = '0; done = 1'b0;
        repeat (5) tick();
        rst = 1'b0;
        tick();
        check(active_n == 1'b1, "R1 reset active_n", active_n, 1);
        check(!serial_o && !frame_load && !req, "R1 reset outputs",
              {serial_o, frame_load, req}, 0);

        // R1 R7: idle bit enables and a stray done do nothing
        done_left = 2;
        for (int t = 0; t < 30; t++) begin
            tick();
            check(active_n && !frame_load && !serial_o && !req, "R1 idle",
                  {active_n, frame_load, serial_o, req}, 8);
        end

        run_burst(0, 5, 1'b0);   // ends in 0xA5
        run_burst(5, 2, 1'b1);   // R9 restart mid-burst, ends in 0xA5

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

endmodule